// File: doc/BRIEF.md
# Memory-Mapped Character Display Port

This block lets a processor send characters to a display sink over its ordinary load/store bus. Two 16-bit registers are decoded on the bus. A status word reports whether the port can take a character and holds an interrupt-enable control. A data word takes the character in its low byte. Software either polls the status word until the ready flag is set, or enables the interrupt and waits for the request. It then stores the next character.

A store to the data word while the port is ready latches the low byte and clears the ready flag. The byte is then offered to the sink with a valid strobe, and the strobe stays up until the sink pulses done. That pulse raises the ready flag again. Stores to the data word made while the port is busy are dropped. The interrupt request is high whenever both the ready flag and the enable bit are set.

Top module: `disp_port`

## Requirements
- R1: After reset the ready flag is 1, the interrupt-enable bit is 0, `disp_valid` is 0 and `irq` is 0.
- R2: A read at address 0xFE04 returns the ready flag in bit 15 and the interrupt-enable bit in bit 14. All other bits read as 0.
- R3: A bus write to 0xFE06 while ready has the following effect from the next clock edge: `disp_valid` is 1, `disp_char` equals write data bits [7:0], and status bit 15 reads 0.
- R4: While `disp_valid` is 1 and `disp_done` is 0, `disp_valid` and `disp_char` hold their values.
- R5: A `disp_done` pulse while `disp_valid` is 1 drops `disp_valid` and sets the ready flag at the next edge.
- R6: A write to 0xFE06 while busy is ignored. The presented character is unchanged, and no new character is offered after the sink finishes.
- R7: A write to 0xFE04 loads write data bit 14 into the interrupt-enable bit. No other bit of that write has any effect, including on the ready flag.
- R8: `irq` is 1 exactly when the ready flag and the interrupt-enable bit are both 1.
- R9: Bus accesses to any address other than 0xFE04 and 0xFE06 change nothing, and reads of such addresses return 0.
- R10: A `disp_done` pulse while the port is idle has no effect.
- R11: A read at 0xFE06 returns the last accepted character in bits [7:0], with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address |
| disp_valid | output | 1 | Character offered to the sink |
| disp_char | output | 8 | Character to display |
| disp_done | input | 1 | Sink finished, single-cycle pulse |
| irq | output | 1 | Interrupt request |

## Verification
A ready flag stuck low would show up at once as a status word of 0x0000 and a missing interrupt. A ready flag that is set too early would cause a second store during a busy period to replace the visible character one cycle later. A corrupted enable bit shows on `irq` in the same cycle it goes wrong. Losing the held character shows on `disp_char` before `disp_done` arrives. Each of these faults therefore appears at the ports within one clock of the fault.

// File: rtl/disp_port_pkg.sv
package disp_port_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned CHAR_W = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [CHAR_W-1:0] char_t;

  // Status word: ready and enable at their bit slots, zero elsewhere.
  function automatic word_t f_status_word(input logic ready, input logic ie,
                                          input int unsigned rdy_pos,
                                          input int unsigned ie_pos);
    word_t w;
    w = '0;
    w[rdy_pos] = ready;
    w[ie_pos]  = ie;
    return w;
  endfunction

  // Character zero-extended to a bus word.
  function automatic word_t f_char_word(input char_t c);
    return {{(WORD_W-CHAR_W){1'b0}}, c};
  endfunction
endpackage

// File: rtl/disp_port_decode.sv
module disp_port_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06
) (
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_stat,
  output logic              wr_data,
  output logic              rd_stat,
  output logic              rd_data
);
  logic hit_stat, hit_data;

  assign hit_stat = sel && (addr == STAT_ADDR);
  assign hit_data = sel && (addr == DATA_ADDR);
  assign wr_stat  = hit_stat && we;
  assign wr_data  = hit_data && we;
  assign rd_stat  = hit_stat && !we;
  assign rd_data  = hit_data && !we;
endmodule

// File: rtl/disp_port_ctrl.sv
module disp_port_ctrl
  import disp_port_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_data,
  input  char_t wchar,
  input  logic  done,
  output logic  busy,
  output char_t char_q,
  output logic  accept_evt,
  output logic  drop_evt,
  output logic  release_evt
);
  assign accept_evt  = wr_data && !busy;
  assign drop_evt    = wr_data && busy;
  assign release_evt = done && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      char_q <= '0;
    end else if (accept_evt) begin
      busy   <= 1'b1;
      char_q <= wchar;
    end else if (release_evt) begin
      busy   <= 1'b0;
    end
  end

  AST_ACCEPT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> busy && (char_q == $past(wchar))); // R3
  AST_HOLD_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy && $stable(char_q)); // R4
  AST_DONE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> !busy); // R5
  AST_BUSY_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> $stable(char_q)); // R6
  AST_IDLE_DONE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && done && !wr_data |=> !busy); // R10
endmodule

// File: rtl/disp_port_irq.sv
module disp_port_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_stat,
  input  logic ie_wbit,
  input  logic ready,
  output logic ie_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ie_q <= 1'b0;
    else if (wr_stat) ie_q <= ie_wbit;
  end

  assign irq = ie_q && ready;

  AST_IE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat |=> ie_q == $past(ie_wbit)); // R7
  AST_IE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> $stable(ie_q)); // R7
endmodule

// File: rtl/disp_port.sv
module disp_port
  import disp_port_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 16'hFE04,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 16'hFE06,
  parameter int unsigned RDY_BIT   = 15,
  parameter int unsigned IE_BIT    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              disp_valid,
  output logic [CHAR_W-1:0] disp_char,
  input  logic              disp_done,
  output logic              irq
);
  logic  wr_stat, wr_data, rd_stat, rd_data;
  logic  busy, ie_q, ready;
  logic  accept_evt, drop_evt, release_evt;
  char_t char_q;
  logic  unused_wdata;

  assign unused_wdata = ^bus_wdata;

  disp_port_decode #(.ADDR_W(ADDR_W), .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR))
  u_decode (
    .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wr_stat(wr_stat), .wr_data(wr_data), .rd_stat(rd_stat), .rd_data(rd_data)
  );

  disp_port_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wchar(bus_wdata[CHAR_W-1:0]),
    .done(disp_done), .busy(busy), .char_q(char_q),
    .accept_evt(accept_evt), .drop_evt(drop_evt), .release_evt(release_evt)
  );

  assign ready = !busy;

  disp_port_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .ie_wbit(bus_wdata[IE_BIT]),
    .ready(ready), .ie_q(ie_q), .irq(irq)
  );

  always_comb begin
    if (rd_stat)      bus_rdata = f_status_word(ready, ie_q, RDY_BIT, IE_BIT);
    else if (rd_data) bus_rdata = f_char_word(char_q);
    else              bus_rdata = '0;
  end

  assign disp_valid = busy;
  assign disp_char  = char_q;

  AST_NO_WRITE_EFFECT_OFFMAP: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sel && bus_we && !wr_stat && !wr_data |=> $stable(disp_valid) || $past(disp_done)); // R9
  AST_READY_NOT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stat && !disp_done |=> $stable(disp_valid)); // R7
  AST_IRQ_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !disp_valid); // R8
  AST_STATUS_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |-> (bus_rdata & ~f_status_word(1'b1, 1'b1, RDY_BIT, IE_BIT)) == '0); // R2
endmodule

// File: tb/disp_port_bench.sv
module disp_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [15:0] bus_addr = '0, bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        disp_valid, disp_done = 1'b0, irq;
  logic [7:0]  disp_char;
  int          n_chk = 0, n_bad = 0;

  localparam logic [15:0] A_STAT = 16'hFE04, A_DATA = 16'hFE06;

  always #10 clk = ~clk;

  disp_port u_disp_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .disp_valid(disp_valid), .disp_char(disp_char), .disp_done(disp_done), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] stat_exp(input logic rdy, input logic ie);
    return {rdy, ie, 14'd0};
  endfunction

  task automatic bus_wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse_done();
    @(negedge clk); disp_done = 1'b1;
    @(negedge clk); disp_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] r;
    chk("R1 valid", disp_valid, 0);
    chk("R1 irq", irq, 0);
    bus_rd(A_STAT, r); chk("R1/R2 status", r, stat_exp(1, 0));
    bus_rd(A_DATA, r); chk("R11 data after reset", r, 0);
  endtask

  task automatic t_single();
    logic [15:0] r;
    bus_wr(A_DATA, 16'hAB41);
    chk("R3 valid", disp_valid, 1);
    chk("R3 char", disp_char, 8'h41);
    bus_rd(A_STAT, r); chk("R3 status busy", r, stat_exp(0, 0));
    repeat (3) @(negedge clk);
    chk("R4 valid held", disp_valid, 1);
    chk("R4 char held", disp_char, 8'h41);
    pulse_done();
    chk("R5 valid low", disp_valid, 0);
    bus_rd(A_STAT, r); chk("R5 ready", r, stat_exp(1, 0));
    bus_rd(A_DATA, r); chk("R11 data read", r, 16'h0041);
  endtask

  task automatic t_busy_drop();
    bus_wr(A_DATA, 16'h0052);
    bus_wr(A_DATA, 16'h0099);
    chk("R6 char kept", disp_char, 8'h52);
    chk("R6 still valid", disp_valid, 1);
    // done and a new write in the same cycle: write is still dropped
    @(negedge clk);
    disp_done = 1'b1; bus_sel = 1'b1; bus_we = 1'b1; bus_addr = A_DATA; bus_wdata = 16'h0077;
    @(negedge clk);
    disp_done = 1'b0; bus_sel = 1'b0; bus_we = 1'b0;
    chk("R6 no new valid", disp_valid, 0);
    repeat (2) @(negedge clk);
    chk("R6 still idle", disp_valid, 0);
    chk("R6 char unchanged", disp_char, 8'h52);
  endtask

  task automatic t_irq();
    logic [15:0] r;
    bus_wr(A_STAT, 16'h4000);
    chk("R8 irq on", irq, 1);
    bus_rd(A_STAT, r); chk("R7 ie set", r, stat_exp(1, 1));
    bus_wr(A_DATA, 16'h0033);
    chk("R8 irq off busy", irq, 0);
    bus_wr(A_STAT, 16'hFFFF);
    bus_rd(A_STAT, r); chk("R7 ready not writable", r, stat_exp(0, 1));
    chk("R7 valid untouched", disp_valid, 1);
    pulse_done();
    chk("R8 irq after done", irq, 1);
    bus_wr(A_STAT, 16'hBFFF);
    chk("R8 irq cleared", irq, 0);
    bus_rd(A_STAT, r); chk("R7 ie cleared", r, stat_exp(1, 0));
  endtask

  task automatic t_offmap();
    logic [15:0] r;
    bus_wr(16'hFE05, 16'h00AA);
    bus_wr(16'hFE02, 16'h4000);
    chk("R9 no valid", disp_valid, 0);
    chk("R9 no irq", irq, 0);
    chk("R9 char kept", disp_char, 8'h33);
    bus_rd(16'hFE00, r); chk("R9 read zero", r, 0);
    bus_rd(A_STAT, r); chk("R9 status intact", r, stat_exp(1, 0));
  endtask

  task automatic t_idle_done();
    logic [15:0] r;
    pulse_done();
    chk("R10 valid", disp_valid, 0);
    bus_rd(A_STAT, r); chk("R10 status", r, stat_exp(1, 0));
    bus_wr(A_DATA, 16'h00E5);
    chk("R10 accepts after", disp_char, 8'hE5);
    pulse_done();
  endtask

  initial begin : watchdog
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_single();
    t_busy_drop();
    t_irq();
    t_offmap();
    t_idle_done();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule